// File: doc/BRIEF.md
# Parallel quad DAC register front end

This block is the digital front end of a four-channel, 8-bit voltage DAC that a host loads over an 8-bit parallel bus. A 2-bit address picks one of four input registers. While the active-low write strobe is low, the picked register follows the bus. A second, active-low load strobe moves all four input registers into the DAC registers at once. The DAC registers drive the four output codes that feed the converters.

Both stages are level-sensitive: a stage follows its source for as long as its strobe is low, and it holds when the strobe goes high. All inputs are sampled on the rising clock edge and the outputs come from registers, so a change reaches the outputs one clock after it is sampled. When the write and load strobes are sampled low together, a new value passes through both stages in that same clock. Holding the load strobe low turns the block into a single-buffered interface. Preloading the input registers with the load strobe high and then pulsing it low updates all four channels together. A shutdown request raises a global off flag. It leaves every register as it is.

Top module: `qdac_par_front`

## Requirements
- R1: While `rst_n` is low, every input register and every DAC register is zero, so `code_o` reads 0 and `off_o` reads 0.
- R2: Address value 0 selects channel 0, 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3. Channel n is driven on `code_o[8n+7:8n]`. Bus bit 7 is the MSB and lands in bit 7 of the channel's code.
- R3: When `wr_n` is sampled low, the addressed input register takes the bus value sampled at that edge.
- R4: When `wr_n` is sampled high, no input register changes, whatever `bus_addr` and `bus_data` carry.
- R5: During a write, the three channels that are not addressed keep their input and DAC values.
- R6: After `wr_n` goes high, the addressed register keeps the last value sampled while `wr_n` was low. A bus change after that point has no effect.
- R7: While `ld_n` is sampled high, `code_o` does not change, even while the input registers are being written.
- R8: When `ld_n` is sampled low, all four DAC registers take the values their input registers hold after that edge, all in the same clock. A write sampled at the same edge therefore reaches `code_o` one clock later.
- R9: `off_o` equals `shdn_req` sampled at the previous edge. Shutdown changes no register: `code_o` holds while it is asserted, writes and loads made during shutdown are still accepted, and the codes are unchanged when shutdown is released.
- R10: With `ld_n` held low, each write shows on its channel's code one clock after it is sampled, which gives single-buffered operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_data | input | 8 | Parallel data, bit 7 is the MSB |
| bus_addr | input | 2 | Channel select, decoded only while `wr_n` is low |
| wr_n | input | 1 | Active-low, level-sensitive write strobe for the input registers |
| ld_n | input | 1 | Active-low, level-sensitive load strobe for all DAC registers |
| shdn_req | input | 1 | Request to put all four outputs in their off state |
| code_o | output | 32 | Four DAC codes, channel n in bits 8n+7..8n |
| off_o | output | 1 | Global shutdown flag |

## Verification
The main write path is driven with the load strobe held low. A different pattern goes to each of the four addresses, which separates the address mapping and catches bit reversal on the bus. Holding the write strobe low over several cycles while the data changes shows that the register follows the bus, and the check after the strobe rises shows that the last value is kept. Bus and address activity with the write strobe high shows that the inputs are ignored. Writes with the load strobe high, followed by a one-cycle load pulse, separate the double-buffered path from the transparent path. A write during shutdown shows that shutdown leaves the registers alone.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    // Default geometry of the front end
    localparam int unsigned QDAC_CHANNELS = 4;
    localparam int unsigned QDAC_CODE_W   = 8;
    // Reset value of every code register (zero scale)
    localparam logic [QDAC_CODE_W-1:0] QDAC_ZERO_CODE = '0;
endpackage

// File: rtl/qdac_addr_dec.sv
module qdac_addr_dec #(
    parameter int unsigned CHANNELS = qdac_pkg::QDAC_CHANNELS,
    localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
    input  logic                en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [CHANNELS-1:0] sel
);
    // One select line per channel, active only while the write strobe is low
    for (genvar g = 0; g < CHANNELS; g++) begin : g_sel
        always_comb begin
            sel[g] = en && (addr == ADDR_W'(g));
        end
    end
endmodule

// File: rtl/qdac_input_bank.sv
module qdac_input_bank #(
    parameter int unsigned CHANNELS = qdac_pkg::QDAC_CHANNELS,
    parameter int unsigned CODE_W   = qdac_pkg::QDAC_CODE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CHANNELS-1:0]              sel,
    input  logic [CODE_W-1:0]                data,
    output logic [CHANNELS-1:0][CODE_W-1:0]  in_d,
    output logic [CHANNELS-1:0][CODE_W-1:0]  in_q
);
    typedef struct packed {
        logic [CHANNELS-1:0][CODE_W-1:0] lat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CHANNELS; i++) begin
            if (sel[i]) begin
                st_d.lat[i] = data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lat: {CHANNELS{qdac_pkg::QDAC_ZERO_CODE}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_d = st_d.lat;
    assign in_q = st_q.lat;

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> $stable(in_q)); // R4

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
        AST_SEL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            sel[g] |=> (in_q[g] == $past(data))); // R3

        AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[g] |=> $stable(in_q[g])); // R5
    end
endmodule

// File: rtl/qdac_hold_bank.sv
module qdac_hold_bank #(
    parameter int unsigned CHANNELS = qdac_pkg::QDAC_CHANNELS,
    parameter int unsigned CODE_W   = qdac_pkg::QDAC_CODE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [CHANNELS-1:0][CODE_W-1:0]  in_d,
    output logic [CHANNELS-1:0][CODE_W-1:0]  dac_q
);
    typedef struct packed {
        logic [CHANNELS-1:0][CODE_W-1:0] code;
    } hold_st_t;

    hold_st_t st_d, st_q;

    // Transparent while load is active: takes the next input value so a
    // write and a load sampled together pass through in one clock.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.code = in_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: {CHANNELS{qdac_pkg::QDAC_ZERO_CODE}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_q = st_q.code;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_q)); // R7

    AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dac_q == $past(in_d))); // R8
endmodule

// File: rtl/qdac_par_front.sv
module qdac_par_front #(
    parameter int unsigned CHANNELS = qdac_pkg::QDAC_CHANNELS,
    parameter int unsigned CODE_W   = qdac_pkg::QDAC_CODE_W,
    localparam int unsigned ADDR_W  = $clog2(CHANNELS),
    localparam int unsigned OUT_W   = CHANNELS * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic              shdn_req,
    output logic [OUT_W-1:0]  code_o,
    output logic              off_o
);
    typedef struct packed {
        logic off;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CHANNELS-1:0]             sel;
    logic [CHANNELS-1:0][CODE_W-1:0] in_d;
    logic [CHANNELS-1:0][CODE_W-1:0] in_q;
    logic [CHANNELS-1:0][CODE_W-1:0] dac_q;

    qdac_addr_dec #(
        .CHANNELS (CHANNELS)
    ) i_dec (
        .en   (!wr_n),
        .addr (bus_addr),
        .sel  (sel)
    );

    qdac_input_bank #(
        .CHANNELS (CHANNELS),
        .CODE_W   (CODE_W)
    ) i_inbank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .data  (bus_data),
        .in_d  (in_d),
        .in_q  (in_q)
    );

    qdac_hold_bank #(
        .CHANNELS (CHANNELS),
        .CODE_W   (CODE_W)
    ) i_holdbank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!ld_n),
        .in_d  (in_d),
        .dac_q (dac_q)
    );

    // Shutdown flag: independent of the code path
    always_comb begin
        st_d     = st_q;
        st_d.off = shdn_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{off: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign off_o = st_q.off;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_out
        assign code_o[g*CODE_W +: CODE_W] = dac_q[g];
    end

    AST_SHDN_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_req && wr_n && ld_n) |=> $stable(code_o)); // R9

    AST_STAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !wr_n) |=> (dac_q == in_q)); // R10
endmodule

// File: tb/test_qdac_par_front.sv
module test_qdac_par_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_data;
    logic [1:0]  bus_addr;
    logic        wr_n;
    logic        ld_n;
    logic        shdn_req;
    logic [31:0] code_o;
    logic        off_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] exp_c [4];

    always #4 clk = ~clk;  // 125 MHz

    qdac_par_front i_qdac_par_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_data (bus_data),
        .bus_addr (bus_addr),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .shdn_req (shdn_req),
        .code_o   (code_o),
        .off_o    (off_o)
    );

    function automatic logic [31:0] packed_exp();
        return {exp_c[3], exp_c[2], exp_c[1], exp_c[0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one clock and sample 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_at_neg(input logic w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_n = w; bus_addr = a; bus_data = d;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_n = 1'b1; ld_n = 1'b1; shdn_req = 1'b0;
        bus_addr = 2'd0; bus_data = 8'h00;
        for (int i = 0; i < 4; i++) exp_c[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 codes at reset", code_o, 32'h0);
        check("R1 off at reset", {31'b0, off_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2 R3 R5 R10: single-buffered writes, distinct pattern per address
    task automatic t_single_buffer();
        logic [7:0] pat [4];
        pat[0] = 8'h81; pat[1] = 8'h42; pat[2] = 8'h24; pat[3] = 8'hF0;
        @(negedge clk); ld_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            drive_at_neg(1'b0, 2'(i), pat[i]);
            step();
            exp_c[i] = pat[i];
            check("R2 R3 R5 R10 single-buffered write", code_o, packed_exp());
            drive_at_neg(1'b1, 2'(i), pat[i]);
        end
    endtask

    // R4: write strobe high, bus and address activity ignored
    task automatic t_ignore_idle();
        for (int i = 0; i < 4; i++) begin
            drive_at_neg(1'b1, 2'(i), 8'hA5 ^ 8'(i));
            step();
            check("R4 idle bus ignored", code_o, packed_exp());
        end
    endtask

    // R3 R6: register follows bus while strobe low, keeps the last value
    task automatic t_follow_last();
        logic [7:0] seq [3];
        seq[0] = 8'h11; seq[1] = 8'h22; seq[2] = 8'h33;
        for (int i = 0; i < 3; i++) begin
            drive_at_neg(1'b0, 2'd2, seq[i]);
            step();
            exp_c[2] = seq[i];
            check("R3 follow while strobe low", code_o, packed_exp());
        end
        drive_at_neg(1'b1, 2'd2, 8'h99);
        step();
        check("R6 last value held", code_o, packed_exp());
        step();
        check("R6 last value held later", code_o, packed_exp());
    endtask

    // R7 R8: preload with load high, then one load pulse
    task automatic t_double_buffer();
        logic [7:0] nv [4];
        nv[0] = 8'h01; nv[1] = 8'h80; nv[2] = 8'h7E; nv[3] = 8'hFF;
        @(negedge clk); ld_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            drive_at_neg(1'b0, 2'(i), nv[i]);
            step();
            check("R7 codes hold while load high", code_o, packed_exp());
            drive_at_neg(1'b1, 2'(i), nv[i]);
        end
        @(negedge clk); ld_n = 1'b0;
        step();
        for (int i = 0; i < 4; i++) exp_c[i] = nv[i];
        check("R8 all channels load together", code_o, packed_exp());
        @(negedge clk); ld_n = 1'b1;
        step();
        check("R8 value kept after load rises", code_o, packed_exp());
    endtask

    // R9: shutdown raises the flag and leaves registers intact
    task automatic t_shutdown();
        @(negedge clk); shdn_req = 1'b1;
        step();
        check("R9 off flag set", {31'b0, off_o}, 32'h1);
        check("R9 codes kept in shutdown", code_o, packed_exp());
        @(negedge clk); ld_n = 1'b0;
        drive_at_neg(1'b0, 2'd1, 8'h5A);
        step();
        exp_c[1] = 8'h5A;
        check("R9 write accepted in shutdown", code_o, packed_exp());
        drive_at_neg(1'b1, 2'd1, 8'h5A);
        shdn_req = 1'b0;
        step();
        check("R9 off flag cleared", {31'b0, off_o}, 32'h0);
        check("R9 codes intact after release", code_o, packed_exp());
        @(negedge clk); ld_n = 1'b1;
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 codes cleared by reset", code_o, 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_single_buffer();
        t_ignore_idle();
        t_follow_last();
        t_double_buffer();
        t_shutdown();
        t_reset_again();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule